// File: doc/BRIEF.md
# Byte-to-Serial Parallel Port Shifter

This peripheral sits on the device side of an IEEE 1284 enhanced parallel port. The host performs one data write cycle per byte. During that cycle the block takes the byte from the parallel data bus and shifts it out on a serial data line with its own bit clock. The load is a shift-register device such as a thermal print head or an LED column driver. The block holds the port's wait handshake low for as long as shifting takes. The host's write cycle therefore cannot finish until every bit has left. Software needs one port write per byte and never has to poll.

The three host control lines (chip select, data strobe, write) are asynchronous to the local clock and pass through a synchroniser. The block starts a burst on a synchronised falling edge of the data strobe, but only while chip select and the write line are both low. A bit counter stops the burst after exactly eight shifts. The block then raises wait so the host can end the cycle. Once the strobe has gone high again, the block returns to idle with wait low. It ignores reads, address cycles and strobes aimed at other devices.

Top module: `epp_serial_tx`

## Requirements
- R1: After reset, wait_o, ser_clk and ser_data are all low.
- R2: A data strobe falling edge while cs_n is high (deselected) causes no ser_clk pulse and leaves wait_o low.
- R3: A data strobe falling edge while write_n is high (a read cycle) causes no ser_clk pulse and leaves wait_o low.
- R4: The byte present on host_data when the strobe falls is sent most significant bit first. The value of ser_data at each rising edge of ser_clk is the next bit.
- R5: Each accepted write cycle produces exactly DATA_W (8) rising edges of ser_clk.
- R6: ser_data changes only while ser_clk is low. It is stable for the whole high phase of every bit.
- R7: wait_o stays low during the whole burst. It rises only after the last bit clock has returned low, and ser_clk is low whenever wait_o is high.
- R8: Once high, wait_o remains high while the data strobe stays low. It returns low within SYNC_STAGES+2 clocks after the strobe goes high.
- R9: Each high phase of ser_clk lasts exactly HALF_TICKS clocks. wait_o rises no later than 16*HALF_TICKS+8 clocks after the strobe falls.
- R10: No further shift happens after the eighth bit while the strobe stays low. A fresh strobe falling edge sends the next byte correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local shift clock (about 10 MHz or faster) |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select from host address decoding |
| strobe_n | input | 1 | Active-low data strobe from the host |
| write_n | input | 1 | Active-low write direction line from the host |
| host_data | input | DATA_W | Parallel data bus from the host |
| wait_o | output | 1 | Handshake to host; low means busy or ready to start, high lets the cycle end |
| ser_data | output | 1 | Serial data to the shift-register load |
| ser_clk | output | 1 | Bit clock to the load; data is valid at its rising edge |

## Verification
The bench sends bytes with alternating bits, all ones, all zeros and single set bits at either end. These patterns separate a reversed bit order, a stuck data line and an off-by-one shift from correct behaviour. It also sends strobes while deselected and during read cycles, and each must produce no bit clocks. After each of these, a valid write confirms that the ignored strobe left no state behind. Holding the strobe low well past the end of a burst shows that the counter allows no ninth shift and that wait stays high. Two back-to-back writes then show that the block re-arms on the next strobe edge.

// File: rtl/epp_ser_pkg.sv
package epp_ser_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HOLD  = 2'd2
    } ctl_state_e;

    typedef struct packed {
        ctl_state_e state;
        logic       strobe_prev;
    } ctl_regs_t;

endpackage

// File: rtl/epp_ser_sync.sv
module epp_ser_sync #(
    parameter int          WIDTH     = 3,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= RESET_VAL;
            end
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/epp_ser_shifter.sv
module epp_ser_shifter #(
    parameter int DATA_W     = 8,
    parameter int HALF_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] byte_i,
    output logic              sdata_o,
    output logic              sclk_o,
    output logic              done_o
);

    localparam int CNT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int TICK_W = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
    localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(DATA_W - 1);
    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(HALF_TICKS - 1);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic [TICK_W-1:0] tick;
        logic              phase;
        logic              active;
        logic              done;
    } shift_regs_t;

    shift_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (!r_q.active) begin
            if (start_i) begin
                r_d.sh     = byte_i;
                r_d.cnt    = '0;
                r_d.tick   = '0;
                r_d.phase  = 1'b0;
                r_d.active = 1'b1;
            end
        end else if (r_q.tick == LAST_TICK) begin
            r_d.tick = '0;
            if (!r_q.phase) begin
                r_d.phase = 1'b1;
            end else begin
                r_d.phase = 1'b0;
                r_d.sh    = r_q.sh << 1;
                if (r_q.cnt == LAST_BIT) begin
                    r_d.active = 1'b0;
                    r_d.done   = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
        end else begin
            r_d.tick = r_q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sdata_o = r_q.active & r_q.sh[DATA_W-1];
    assign sclk_o  = r_q.active & r_q.phase;
    assign done_o  = r_q.done;

endmodule

// File: rtl/epp_serial_tx.sv
module epp_serial_tx
    import epp_ser_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int HALF_TICKS  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              strobe_n,
    input  logic              write_n,
    input  logic [DATA_W-1:0] host_data,
    output logic              wait_o,
    output logic              ser_data,
    output logic              ser_clk
);

    localparam int CTL_W = 3;

    logic [CTL_W-1:0] ctl_sync;
    logic             cs_s, strobe_s, write_s;
    logic             start, done;

    ctl_regs_t c_d, c_q;

    epp_ser_sync #(
        .WIDTH    (CTL_W),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL('1)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({cs_n, strobe_n, write_n}),
        .sync_o (ctl_sync)
    );

    assign {cs_s, strobe_s, write_s} = ctl_sync;

    always_comb begin
        c_d             = c_q;
        c_d.strobe_prev = strobe_s;
        start           = 1'b0;
        case (c_q.state)
            ST_IDLE: begin
                if (c_q.strobe_prev && !strobe_s && !cs_s && !write_s) begin
                    start     = 1'b1;
                    c_d.state = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (done) c_d.state = ST_HOLD;
            end
            ST_HOLD: begin
                if (strobe_s) c_d.state = ST_IDLE;
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.state       <= ST_IDLE;
            c_q.strobe_prev <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    epp_ser_shifter #(
        .DATA_W    (DATA_W),
        .HALF_TICKS(HALF_TICKS)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start),
        .byte_i (host_data),
        .sdata_o(ser_data),
        .sclk_o (ser_clk),
        .done_o (done)
    );

    assign wait_o = (c_q.state == ST_HOLD);

endmodule

// File: rtl/epp_serial_tx_chk.sv
module epp_serial_tx_chk #(
    parameter int DATA_W = 8
) (
    input logic clk,
    input logic rst_n,
    input logic strobe_n,
    input logic wait_o,
    input logic ser_data,
    input logic ser_clk
);

    logic       sclk_prev_q, wait_prev_q;
    logic [7:0] rise_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
            wait_prev_q <= 1'b0;
            rise_cnt_q  <= '0;
        end else begin
            sclk_prev_q <= ser_clk;
            wait_prev_q <= wait_o;
            if (wait_prev_q && !wait_o) begin
                rise_cnt_q <= '0;
            end else if (ser_clk && !sclk_prev_q) begin
                rise_cnt_q <= rise_cnt_q + 1'b1;
            end
        end
    end

    // R5: never more than DATA_W bit clocks per cycle
    a_r5_burst_limit: assert property (@(posedge clk) disable iff (!rst_n)
        rise_cnt_q <= 8'(DATA_W));

    // R6: data held while the bit clock is high
    a_r6_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

    // R7: wait released only after a full burst
    a_r7_wait_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wait_o) |-> (rise_cnt_q == 8'(DATA_W)));

    // R7: no bit clock while wait is high
    a_r7_quiet_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        wait_o |-> !ser_clk);

    // R8: wait drops only after the strobe has returned high
    a_r8_wait_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wait_o) |-> $past(strobe_n));

endmodule

bind epp_serial_tx epp_serial_tx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe_n(strobe_n),
    .wait_o  (wait_o),
    .ser_data(ser_data),
    .ser_clk (ser_clk)
);

// File: tb/epp_serial_tx_test.sv
module epp_serial_tx_test;

    localparam int DATA_W     = 8;
    localparam int HALF_TICKS = 2;
    localparam int SYNC       = 2;
    localparam int WAIT_LIMIT = 16 * HALF_TICKS + 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic strobe_n = 1'b1;
    logic write_n = 1'b1;
    logic [DATA_W-1:0] host_data = '0;
    logic wait_o, ser_data, ser_clk;

    int checks = 0;
    int errors = 0;
    int rises = 0;
    int rises_while_wait = 0;
    int bad_high_width = 0;
    logic [DATA_W-1:0] captured = '0;

    always #5 clk = ~clk;

    epp_serial_tx #(
        .DATA_W(DATA_W), .HALF_TICKS(HALF_TICKS), .SYNC_STAGES(SYNC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .strobe_n(strobe_n),
        .write_n(write_n), .host_data(host_data),
        .wait_o(wait_o), .ser_data(ser_data), .ser_clk(ser_clk)
    );

    always @(posedge ser_clk) begin
        rises = rises + 1;
        captured = {captured[DATA_W-2:0], ser_data};
        if (wait_o) rises_while_wait = rises_while_wait + 1;
    end

    int hi_run = 0;
    always @(negedge clk) begin
        if (ser_clk) begin
            hi_run = hi_run + 1;
        end else begin
            if (hi_run != 0 && hi_run != HALF_TICKS) bad_high_width = bad_high_width + 1;
            hi_run = 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        rises = 0;
        rises_while_wait = 0;
        bad_high_width = 0;
        captured = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!wait_o && !ser_clk && !ser_data, "R1 reset outputs",
              {wait_o, ser_clk, ser_data}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!wait_o && !ser_clk, "R1 after reset release", {wait_o, ser_clk}, 0);
    endtask

    task automatic send_byte(input logic [DATA_W-1:0] b);
        int n;
        @(negedge clk);
        clear_mon();
        cs_n = 1'b0; write_n = 1'b0; host_data = b;
        repeat (2) @(negedge clk);
        strobe_n = 1'b0;
        n = 0;
        while (!wait_o && n < 400) begin
            @(negedge clk);
            n = n + 1;
        end
        check(n <= WAIT_LIMIT, "R9 wait rise latency", n, WAIT_LIMIT);
        check(rises == DATA_W, "R5 bit clock count", rises, DATA_W);
        check(captured == b, "R4 msb-first byte", captured, b);
        check(rises_while_wait == 0 && !ser_clk, "R7 wait only after burst",
              rises_while_wait, 0);
        check(bad_high_width == 0, "R9 high phase width", bad_high_width, 0);
        repeat (20) @(negedge clk);
        check(wait_o == 1'b1, "R8 wait held while strobe low", wait_o, 1);
        check(rises == DATA_W, "R10 no extra shifts", rises, DATA_W);
        strobe_n = 1'b1;
        n = 0;
        while (wait_o && n < 50) begin
            @(negedge clk);
            n = n + 1;
        end
        check(n <= SYNC + 2, "R8 wait release latency", n, SYNC + 2);
        cs_n = 1'b1; write_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic ignored_strobe(input logic cs_v, input logic wr_v, input string req);
        @(negedge clk);
        clear_mon();
        cs_n = cs_v; write_n = wr_v; host_data = 8'hFF;
        repeat (2) @(negedge clk);
        strobe_n = 1'b0;
        repeat (60) @(negedge clk);
        check(rises == 0, req, rises, 0);
        check(wait_o == 1'b0, req, wait_o, 0);
        strobe_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b1; write_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        fork
            begin
                do_reset();
                send_byte(8'hA5);
                send_byte(8'h5A);
                send_byte(8'hFF);
                send_byte(8'h00);
                send_byte(8'h80);
                send_byte(8'h01);
                ignored_strobe(1'b1, 1'b0, "R2 deselected strobe ignored");
                send_byte(8'h3C);
                ignored_strobe(1'b0, 1'b1, "R3 read cycle ignored");
                send_byte(8'hC3);
                send_byte(8'h96); // R10 back-to-back cycle
            end
            begin
                repeat (100000) @(negedge clk);
                checks = checks + 1;
                errors = errors + 1;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule